// File: doc/BRIEF.md
# ADC power mode sequencer

This block controls the power of the two analog converters of a scanning ADC. Each converter has a power-down control input. A programmable power-up delay sets how long the block waits before a converter counts as ready. A status flag per converter reports when the converter is not yet usable. A scan request is either granted or dropped, depending on which converters the scan needs and whether those converters are ready.

There are three power policies, and they share one delay counter:
- **Normal:** the delay runs only when a converter is switched on. After that, scans start without waiting.
- **Auto standby:** enabled converters are held at reduced current while the block is idle. The delay runs each time a scan starts.
- **Auto power-down:** converters are fully off while the block is idle. When a scan starts, only the converters in the scan's required mask are powered, and the delay runs before the grant.

If both low-power enables are set, auto power-down wins. The analog side is modelled only as an enable output and a full-current output per converter.

Top module: `adc_pwr_seq`

## Requirements
- R1: While `rst_ni` is low, `pwr_busy_o` is all ones, `scan_grant_o` and `scan_active_o` are 0, and the block is idle.
- R2: Bit n of `pd_i` equal to 1 keeps converter n off (`conv_en_o[n]`=0, `conv_full_o[n]`=0) and sets `pwr_busy_o[n]` at the next clock. In normal mode `conv_en_o[n]` and `conv_full_o[n]` equal the inverse of `pd_i[n]`.
- R3: In normal mode, when `pd_i[n]` is cleared for a busy converter, `pwr_busy_o[n]` clears on the (D+1)-th rising edge after the change, where D is `pu_dly_i`. D=0 clears it on the first edge.
- R4: In normal mode, an idle-state request whose nonzero `req_mask_i` names only non-busy converters is accepted. `scan_grant_o` and `scan_active_o` rise at the next edge, with no added delay.
- R5: A request naming a busy converter, or arriving while the delay counts, is dropped. It does not produce a later grant.
- R6: In auto standby (`asb_en_i`=1, `apd_en_i`=0), enabled converters are idle at reduced current (`conv_en_o`=1, `conv_full_o`=0) with busy set. An accepted request raises full current on all enabled converters. The grant follows D+1 edges after acceptance, and the busy flags clear at the same time.
- R7: In auto power-down, idle converters are off. An accepted request powers only the converters named in `req_mask_i` at acceptance. The grant follows D+1 edges later, and only those converters' busy flags clear.
- R8: With both `asb_en_i` and `apd_en_i` set, auto power-down behaviour applies.
- R9: `scan_done_i` high while active returns the block to idle at the next edge. In a low-power mode the converters drop to standby or off on that edge and all busy flags are set. Normal mode keeps them powered.
- R10: `scan_grant_o` lasts exactly one cycle. Requests made while a scan is active are ignored.
- R11: In a low-power mode, a request with an empty mask, or with a mask naming a converter whose `pd_i` bit is 1, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | N_CONV | Power-down control per converter, 1 = off |
| asb_en_i | input | 1 | Auto standby enable |
| apd_en_i | input | 1 | Auto power-down enable (dominant) |
| pu_dly_i | input | DLY_W | Power-up delay in clock cycles |
| req_mask_i | input | N_CONV | Converters required by the pending scan |
| scan_req_i | input | 1 | Scan start request |
| scan_done_i | input | 1 | Scan finished, return to idle |
| conv_en_o | output | N_CONV | Converter power enable |
| conv_full_o | output | N_CONV | Converter at full current |
| pwr_busy_o | output | N_CONV | Converter down or still powering up |
| scan_grant_o | output | 1 | One-cycle pulse on scan acceptance |
| scan_active_o | output | 1 | Scan in progress |

## Verification
The tests look for faults in internal state that become visible on the ports. A counter that reloads or decrements wrongly moves the falling edge of `pwr_busy_o` or the `scan_grant_o` pulse by whole cycles, and the exact-cycle checks detect this within D+2 edges. A latched target mask or state register that is wrong shows up on `conv_en_o` and `conv_full_o` one edge after a request or a done. A request that is wrongly queued instead of dropped shows up as a grant that nothing asked for in the cycles after the converters become ready.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACTIVE} pwr_state_e;
  typedef enum logic [1:0] {PM_NORMAL, PM_STANDBY, PM_OFF} pwr_mode_e;
endpackage

// File: rtl/adc_pwr_delay.sv
module adc_pwr_delay #(
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             counting_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] rem;

  // first cycle of a run takes the programmed value directly, so 0 means no wait
  assign rem    = counting_q ? cnt_q : dly_i;
  assign done_o = run_i && (rem == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      counting_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!run_i || done_o) begin
      counting_q <= 1'b0;
    end else begin
      counting_q <= 1'b1;
      cnt_q      <= rem - ONE;
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int unsigned N_CONV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pwr_mode_e         mode_i,
  input  logic [N_CONV-1:0] pd_i,
  input  logic [N_CONV-1:0] req_mask_i,
  input  logic              scan_req_i,
  input  logic              scan_done_i,
  input  logic              dly_done_i,
  output pwr_state_e        state_o,
  output logic [N_CONV-1:0] target_o,
  output logic [N_CONV-1:0] busy_o,
  output logic              grant_o,
  output logic              run_o
);
  pwr_state_e        state_q, state_d;
  logic [N_CONV-1:0] target_q, target_d, busy_q, busy_d;
  logic              grant_q, lowpwr, idle_req, acc_norm, acc_lp;

  assign lowpwr   = (mode_i != PM_NORMAL);
  assign idle_req = (state_q == ST_IDLE) && scan_req_i && (|req_mask_i);
  assign acc_norm = !lowpwr && idle_req && ((req_mask_i & busy_q) == '0);
  assign acc_lp   = lowpwr && idle_req && ((req_mask_i & pd_i) == '0);

  // normal mode: counter runs while any switched-on converter is not ready
  assign run_o = lowpwr ? (state_q == ST_WAIT) : (|(busy_q & ~pd_i));

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_norm) begin
          state_d  = ST_ACTIVE;
          target_d = req_mask_i;
        end else if (acc_lp) begin
          state_d  = ST_WAIT;
          target_d = (mode_i == PM_OFF) ? (req_mask_i & ~pd_i) : ~pd_i;
        end
      end
      ST_WAIT:   if (dly_done_i) state_d = ST_ACTIVE;
      ST_ACTIVE: if (scan_done_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    if (!lowpwr && dly_done_i) busy_d = busy_q & pd_i;
    if (lowpwr && state_q == ST_WAIT && dly_done_i) busy_d = busy_q & ~target_q;
    if (lowpwr && (state_q == ST_IDLE || (state_q == ST_ACTIVE && scan_done_i)))
      busy_d = '1;
    busy_d = busy_d | pd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      busy_q   <= '1;
      grant_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
      busy_q   <= busy_d;
      grant_q  <= acc_norm || (state_q == ST_WAIT && dly_done_i);
    end
  end

  assign state_o  = state_q;
  assign target_o = target_q;
  assign busy_o   = busy_q;
  assign grant_o  = grant_q;
endmodule

// File: rtl/adc_pwr_drive.sv
module adc_pwr_drive
  import adc_pwr_pkg::*;
#(
  parameter int unsigned N_CONV = 2
) (
  input  pwr_mode_e         mode_i,
  input  pwr_state_e        state_i,
  input  logic [N_CONV-1:0] pd_i,
  input  logic [N_CONV-1:0] target_i,
  output logic [N_CONV-1:0] en_o,
  output logic [N_CONV-1:0] full_o
);
  logic busy_phase;
  assign busy_phase = (state_i != ST_IDLE);

  for (genvar n = 0; n < N_CONV; n++) begin : g_conv
    logic sel;
    assign sel       = busy_phase && target_i[n];
    assign en_o[n]   = !pd_i[n] && ((mode_i == PM_OFF) ? sel : 1'b1);
    assign full_o[n] = !pd_i[n] && ((mode_i == PM_NORMAL) ? 1'b1 : sel);
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned N_CONV = 2,
  parameter int unsigned DLY_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CONV-1:0] pd_i,
  input  logic              asb_en_i,
  input  logic              apd_en_i,
  input  logic [DLY_W-1:0]  pu_dly_i,
  input  logic [N_CONV-1:0] req_mask_i,
  input  logic              scan_req_i,
  input  logic              scan_done_i,
  output logic [N_CONV-1:0] conv_en_o,
  output logic [N_CONV-1:0] conv_full_o,
  output logic [N_CONV-1:0] pwr_busy_o,
  output logic              scan_grant_o,
  output logic              scan_active_o
);
  pwr_mode_e         mode;
  pwr_state_e        state;
  logic [N_CONV-1:0] target;
  logic              run, dly_done;

  assign mode = apd_en_i ? PM_OFF : (asb_en_i ? PM_STANDBY : PM_NORMAL);

  adc_pwr_delay #(.DLY_W(DLY_W)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .dly_i  (pu_dly_i),
    .done_o (dly_done)
  );

  adc_pwr_ctrl #(.N_CONV(N_CONV)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .pd_i        (pd_i),
    .req_mask_i  (req_mask_i),
    .scan_req_i  (scan_req_i),
    .scan_done_i (scan_done_i),
    .dly_done_i  (dly_done),
    .state_o     (state),
    .target_o    (target),
    .busy_o      (pwr_busy_o),
    .grant_o     (scan_grant_o),
    .run_o       (run)
  );

  adc_pwr_drive #(.N_CONV(N_CONV)) i_drive (
    .mode_i   (mode),
    .state_i  (state),
    .pd_i     (pd_i),
    .target_i (target),
    .en_o     (conv_en_o),
    .full_o   (conv_full_o)
  );

  assign scan_active_o = (state == ST_ACTIVE);
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int unsigned N_CONV = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CONV-1:0] pd_i,
  input logic              asb_en_i,
  input logic              apd_en_i,
  input logic              scan_done_i,
  input logic [N_CONV-1:0] conv_en_o,
  input logic [N_CONV-1:0] conv_full_o,
  input logic [N_CONV-1:0] pwr_busy_o,
  input logic              scan_grant_o,
  input logic              scan_active_o
);
  for (genvar n = 0; n < N_CONV; n++) begin : g_pd
    p_pd_sets_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd_i[n] |=> pwr_busy_o[n]);
    p_pd_forces_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd_i[n] |-> !conv_en_o[n]);
  end

  p_full_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_full_o & ~conv_en_o) == '0);

  p_grant_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_grant_o |-> scan_active_o);

  p_grant_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_grant_o |=> !scan_grant_o);

  p_done_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_active_o && scan_done_i |=> !scan_active_o);

  p_lowpwr_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asb_en_i || apd_en_i) && scan_active_o && scan_done_i |=> (&pwr_busy_o));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.N_CONV(N_CONV)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pd_i          (pd_i),
  .asb_en_i      (asb_en_i),
  .apd_en_i      (apd_en_i),
  .scan_done_i   (scan_done_i),
  .conv_en_o     (conv_en_o),
  .conv_full_o   (conv_full_o),
  .pwr_busy_o    (pwr_busy_o),
  .scan_grant_o  (scan_grant_o),
  .scan_active_o (scan_active_o)
);

// File: tb/test_adc_pwr_seq.sv
`timescale 1ns/1ps
module test_adc_pwr_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pd_i = 2'b11;
  logic       asb_en_i = 1'b0;
  logic       apd_en_i = 1'b0;
  logic [5:0] pu_dly_i = 6'd3;
  logic [1:0] req_mask_i = 2'b00;
  logic       scan_req_i = 1'b0;
  logic       scan_done_i = 1'b0;
  logic [1:0] conv_en_o, conv_full_o, pwr_busy_o;
  logic       scan_grant_o, scan_active_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_pwr_seq i_adc_pwr_seq (.*);

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 busy", {6'd0, pwr_busy_o}, 8'h3);
    chk("R1 grant/active", {6'd0, scan_grant_o, scan_active_o}, 8'h0);
    chk("R1 en", {6'd0, conv_en_o}, 8'h0);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_normal_powerup;
    pu_dly_i = 6'd3;
    pd_i = 2'b10;
    #1;
    chk("R2 en follows pd", {6'd0, conv_en_o}, 8'h1);
    chk("R2 full follows pd", {6'd0, conv_full_o}, 8'h1);
    step(3);
    chk("R3 still busy after D edges", {6'd0, pwr_busy_o}, 8'h3);
    step();
    chk("R3 busy clears at D+1", {6'd0, pwr_busy_o}, 8'h2);
  endtask

  task automatic t_normal_scan;
    req_mask_i = 2'b01;
    scan_req_i = 1'b1;
    step();
    chk("R4 grant next edge", {6'd0, scan_grant_o, scan_active_o}, 8'h3);
    scan_req_i = 1'b0;
    step();
    chk("R10 grant one cycle", {6'd0, scan_grant_o, scan_active_o}, 8'h1);
    scan_req_i = 1'b1;
    step(2);
    chk("R10 request while active ignored", {7'd0, scan_grant_o}, 8'h0);
    scan_req_i = 1'b0;
    scan_done_i = 1'b1;
    step();
    scan_done_i = 1'b0;
    chk("R9 normal idle", {7'd0, scan_active_o}, 8'h0);
    chk("R9 normal stays powered", {4'd0, conv_en_o, pwr_busy_o}, 8'h6);
  endtask

  task automatic t_busy_drop;
    req_mask_i = 2'b10;
    scan_req_i = 1'b1;
    step();
    scan_req_i = 1'b0;
    chk("R5 busy converter request dropped", {6'd0, scan_grant_o, scan_active_o}, 8'h0);
    pd_i = 2'b00;
    step();
    req_mask_i = 2'b11;
    scan_req_i = 1'b1;
    step();
    scan_req_i = 1'b0;
    chk("R5 request during delay dropped", {6'd0, scan_grant_o, scan_active_o}, 8'h0);
    step(2);
    chk("R3 second converter ready", {6'd0, pwr_busy_o}, 8'h0);
    step(2);
    chk("R5 not queued", {6'd0, scan_grant_o, scan_active_o}, 8'h0);
    scan_req_i = 1'b1;
    step();
    scan_req_i = 1'b0;
    chk("R4 grant after ready", {6'd0, scan_grant_o, scan_active_o}, 8'h3);
    scan_done_i = 1'b1;
    step();
    scan_done_i = 1'b0;
  endtask

  task automatic t_standby;
    asb_en_i = 1'b1;
    pu_dly_i = 6'd2;
    #1;
    chk("R6 idle reduced current", {4'd0, conv_en_o, conv_full_o}, 8'hC);
    step();
    chk("R6 idle busy", {6'd0, pwr_busy_o}, 8'h3);
    req_mask_i = 2'b01;
    scan_req_i = 1'b1;
    step();
    chk("R6 full on accept", {6'd0, conv_full_o}, 8'h3);
    chk("R6 no grant yet", {6'd0, scan_grant_o, scan_active_o}, 8'h0);
    step();
    scan_req_i = 1'b0;
    chk("R5 request in wait ignored", {7'd0, scan_grant_o}, 8'h0);
    step();
    chk("R6 still waiting", {7'd0, scan_grant_o}, 8'h0);
    step();
    chk("R6 grant after D+1", {6'd0, scan_grant_o, scan_active_o}, 8'h3);
    chk("R6 busy cleared", {6'd0, pwr_busy_o}, 8'h0);
    step();
    chk("R10 standby grant one cycle", {7'd0, scan_grant_o}, 8'h0);
    scan_done_i = 1'b1;
    step();
    scan_done_i = 1'b0;
    chk("R9 back to standby", {3'd0, scan_active_o, conv_en_o, conv_full_o}, 8'hC);
    chk("R9 busy rearmed", {6'd0, pwr_busy_o}, 8'h3);
  endtask

  task automatic t_powerdown;
    apd_en_i = 1'b1;
    pu_dly_i = 6'd1;
    req_mask_i = 2'b10;
    #1;
    chk("R8 off wins over standby", {4'd0, conv_en_o, conv_full_o}, 8'h0);
    step();
    scan_req_i = 1'b1;
    step();
    scan_req_i = 1'b0;
    req_mask_i = 2'b11;
    chk("R7 only required powered", {4'd0, conv_en_o, conv_full_o}, 8'hA);
    step();
    chk("R7 waiting", {7'd0, scan_grant_o}, 8'h0);
    step();
    chk("R7 grant after D+1", {6'd0, scan_grant_o, scan_active_o}, 8'h3);
    chk("R7 only required ready", {6'd0, pwr_busy_o}, 8'h1);
    chk("R7 mask change after accept ignored", {6'd0, conv_en_o}, 8'h2);
    scan_done_i = 1'b1;
    step();
    scan_done_i = 1'b0;
    chk("R9 back to off", {3'd0, scan_active_o, conv_en_o, conv_full_o}, 8'h0);
    chk("R9 off busy rearmed", {6'd0, pwr_busy_o}, 8'h3);
  endtask

  task automatic t_lp_reject;
    pd_i = 2'b01;
    req_mask_i = 2'b01;
    scan_req_i = 1'b1;
    step();
    chk("R11 down converter request ignored", {5'd0, scan_grant_o, conv_en_o}, 8'h0);
    req_mask_i = 2'b00;
    step();
    scan_req_i = 1'b0;
    chk("R11 empty mask ignored", {5'd0, scan_active_o, conv_en_o}, 8'h0);
    step(3);
    chk("R11 nothing granted later", {6'd0, scan_grant_o, scan_active_o}, 8'h0);
  endtask

  task automatic t_zero_delay;
    apd_en_i = 1'b0;
    asb_en_i = 1'b0;
    pd_i = 2'b11;
    step();
    chk("R2 all down busy", {6'd0, pwr_busy_o}, 8'h3);
    pu_dly_i = 6'd0;
    pd_i = 2'b10;
    step();
    chk("R3 zero delay clears on first edge", {6'd0, pwr_busy_o}, 8'h2);
  endtask

  initial begin
    #1;
    t_reset();
    t_normal_powerup();
    t_normal_scan();
    t_busy_drop();
    t_standby();
    t_powerdown();
    t_lp_reject();
    t_zero_delay();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule